// File: doc/BRIEF.md
# Timed Configuration Readback Controller

This block sits beside the program-memory load path of a small microcontroller core. Software arms a short-lived readback mode by writing two enable bits together into the self-programming control register. For a few cycles after that write, a program-memory load whose address pointer selects one of two special addresses returns a stored configuration value instead of flash data. Address 0x0001 returns the lock bits and address 0x0000 returns the fuse low byte.

The mode ends by itself. It ends when a readback load completes, when no load of any kind arrives in the load window, or when the longer store window runs out or a store arrives. While an EEPROM write is in progress the control register cannot be written and no readback takes place. The load result and the redirect flag are registered, so they appear one cycle after the load strobe.

Top module: `cfg_readback_ctrl`

## Requirements
- R1: After reset both enable bits read as 0, `ld_redirect` is 0 and `ld_data` is 0.
- R2: Readback mode is armed only by an accepted write whose data has bit 3 (lock-read enable) and bit 0 (self-programming enable) both set. Any other accepted write disarms it. `ctl_rdata` shows the armed state on bits 3 and 0, with all other bits 0.
- R3: A load in one of the first three cycles after the arming write, with `zptr` equal to 0x0001, yields `ld_data` = {6'b0, lock bits} one cycle later. `lock_val[1]` goes to bit 1 and `lock_val[0]` goes to bit 0.
- R4: A load in the same three-cycle window, with `zptr` equal to 0x0000, yields the full `fuse_val` byte one cycle later.
- R5: A completed lock or fuse readback clears both enable bits at the next edge.
- R6: If no load arrives in the three cycles after arming, both bits clear at the end of the third cycle. A readback load in the fourth cycle returns flash data.
- R7: Once a load with another address has been seen, the mode stays armed until a store arrives or four cycles have passed, whichever comes first.
- R8: A load in the window with a `zptr` other than 0x0000 or 0x0001 returns `flash_rdata` and does not disarm the mode.
- R9: While `ee_busy` is 1, control writes are ignored and loads return `flash_rdata`.
- R10: While disarmed, every load returns `flash_rdata` one cycle later.
- R11: An accepted arming write restarts the window from its first cycle. It takes effect even in a cycle where the mode would otherwise have cleared.
- R12: `ld_redirect` is 1 exactly in the cycle after a load that was served from lock or fuse storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| zptr | input | 16 | Address pointer used by the load |
| ld_req | input | 1 | Program-memory load strobe |
| st_req | input | 1 | Program-memory store strobe |
| ee_busy | input | 1 | EEPROM write in progress |
| lock_val | input | 2 | Stored lock bits |
| fuse_val | input | 8 | Stored fuse low byte |
| flash_rdata | input | 8 | Flash word read for the current load |
| ld_data | output | 8 | Registered load result |
| ld_redirect | output | 1 | Registered flag: result came from configuration storage |

## Verification
Two events can fall in the same cycle: a control write that re-arms the mode, and a load or store that would otherwise finish or expire the window. The bench provokes this by issuing a readback load, and separately a store, in the same cycle as an arming write. The load must still be served from the state before the write, and the bits must come out armed with a fresh window. A behavioural model judges every cycle: it is checked with a lock readback issued at the new window's last legal cycle and with a fuse readback that arrives one cycle too late.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;
  // Control register field positions decoded by software
  localparam int SPM_EN_BIT  = 0;
  localparam int LOCK_RD_BIT = 3;
  localparam int CTL_W       = 8;

  function automatic logic [CTL_W-1:0] ctl_image(input logic armed);
    logic [CTL_W-1:0] v;
    v = '0;
    v[SPM_EN_BIT]  = armed;
    v[LOCK_RD_BIT] = armed;
    return v;
  endfunction
endpackage

// File: rtl/cfgrb_window.sv
module cfgrb_window #(
  parameter int LD_WIN = 3,
  parameter int ST_WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_ok,
  input  logic arm_val,
  input  logic ld_req,
  input  logic ld_hit,
  input  logic st_req,
  output logic armed,
  output logic in_ld_win
);
  localparam int CW = $clog2(ST_WIN + 1);

  logic [CW-1:0] cnt;
  logic          ld_seen;
  logic          ld_expire;
  logic          st_expire;
  logic          finish;

  assign in_ld_win = armed && (cnt < CW'(LD_WIN));
  assign ld_expire = (cnt == CW'(LD_WIN - 1)) && !ld_seen && !ld_req;
  assign st_expire = (cnt == CW'(ST_WIN - 1));
  assign finish    = ld_hit || st_req || ld_expire || st_expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      cnt     <= '0;
      ld_seen <= 1'b0;
    end else if (wr_ok) begin
      armed   <= arm_val;
      cnt     <= '0;
      ld_seen <= 1'b0;
    end else if (armed) begin
      if (finish) begin
        armed   <= 1'b0;
        cnt     <= '0;
        ld_seen <= 1'b0;
      end else begin
        cnt     <= cnt + 1'b1;
        ld_seen <= ld_seen || ld_req;
      end
    end
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt < CW'(ST_WIN)));

  p_rearm_restart_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && arm_val) |=> (armed && cnt == '0));

  p_hit_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_hit && !wr_ok) |=> !armed);

  p_store_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && st_req && !wr_ok) |=> !armed);
endmodule

// File: rtl/cfgrb_select.sv
module cfgrb_select #(
  parameter int DW  = 8,
  parameter int LKW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hit,
  input  logic           pick_fuse,
  input  logic [LKW-1:0] lock_val,
  input  logic [DW-1:0]  fuse_val,
  input  logic [DW-1:0]  flash_rdata,
  output logic [DW-1:0]  ld_data,
  output logic           ld_redirect
);
  logic [DW-1:0] lock_word;
  logic [DW-1:0] nxt;

  assign lock_word = {{(DW-LKW){1'b0}}, lock_val};

  always_comb begin
    if (!hit)          nxt = flash_rdata;
    else if (pick_fuse) nxt = fuse_val;
    else                nxt = lock_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_data     <= '0;
      ld_redirect <= 1'b0;
    end else begin
      ld_data     <= nxt;
      ld_redirect <= hit;
    end
  end

  p_redirect_cause_r12: assert property (@(posedge clk) disable iff (rst)
    ld_redirect |-> $past(hit));
endmodule

// File: rtl/cfg_readback_ctrl.sv
module cfg_readback_ctrl #(
  parameter int DW        = 8,
  parameter int LKW       = 2,
  parameter int ZW        = 16,
  parameter int LD_WIN    = 3,
  parameter int ST_WIN    = 4,
  parameter int LOCK_ADDR = 1,
  parameter int FUSE_ADDR = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ctl_wr,
  input  logic [cfgrb_pkg::CTL_W-1:0] ctl_wdata,
  output logic [cfgrb_pkg::CTL_W-1:0] ctl_rdata,
  input  logic [ZW-1:0]               zptr,
  input  logic                        ld_req,
  input  logic                        st_req,
  input  logic                        ee_busy,
  input  logic [LKW-1:0]              lock_val,
  input  logic [DW-1:0]               fuse_val,
  input  logic [DW-1:0]               flash_rdata,
  output logic [DW-1:0]               ld_data,
  output logic                        ld_redirect
);
  import cfgrb_pkg::*;

  logic wr_ok, arm_val, armed, in_ld_win;
  logic z_lock, z_fuse, hit;

  assign wr_ok   = ctl_wr && !ee_busy;
  assign arm_val = ctl_wdata[SPM_EN_BIT] && ctl_wdata[LOCK_RD_BIT];
  assign z_lock  = (zptr == ZW'(LOCK_ADDR));
  assign z_fuse  = (zptr == ZW'(FUSE_ADDR));
  assign hit     = in_ld_win && !ee_busy && ld_req && (z_lock || z_fuse);
  assign ctl_rdata = ctl_image(armed);

  cfgrb_window #(.LD_WIN(LD_WIN), .ST_WIN(ST_WIN)) u_win (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .arm_val(arm_val),
    .ld_req(ld_req), .ld_hit(hit), .st_req(st_req),
    .armed(armed), .in_ld_win(in_ld_win)
  );

  cfgrb_select #(.DW(DW), .LKW(LKW)) u_sel (
    .clk(clk), .rst(rst), .hit(hit), .pick_fuse(z_fuse),
    .lock_val(lock_val), .fuse_val(fuse_val), .flash_rdata(flash_rdata),
    .ld_data(ld_data), .ld_redirect(ld_redirect)
  );

  p_busy_no_arm_r9: assert property (@(posedge clk) disable iff (rst)
    (ee_busy && !armed) |=> !armed);

  p_busy_flash_r9: assert property (@(posedge clk) disable iff (rst)
    (ee_busy && ld_req) |=> (!ld_redirect && ld_data == $past(flash_rdata)));

  p_idle_flash_r10: assert property (@(posedge clk) disable iff (rst)
    (!armed && ld_req) |=> (!ld_redirect && ld_data == $past(flash_rdata)));
endmodule

// File: tb/cfg_readback_ctrl_test.sv
module cfg_readback_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic [15:0] zptr = 16'h1234;
  logic       ld_req = 1'b0;
  logic       st_req = 1'b0;
  logic       ee_busy = 1'b0;
  logic [1:0] lock_val = 2'b10;
  logic [7:0] fuse_val = 8'hA5;
  logic [7:0] flash_rdata = 8'h00;
  logic [7:0] ld_data;
  logic       ld_redirect;

  int total = 0;
  int bad = 0;
  string tag = "R1";
  bit done = 1'b0;

  // behavioural reference state
  bit   m_armed = 1'b0;
  int   m_cnt = 0;
  bit   m_seen = 1'b0;
  logic [7:0] m_data = '0;
  bit   m_red = 1'b0;

  always #2 clk = ~clk;

  cfg_readback_ctrl uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .zptr(zptr), .ld_req(ld_req), .st_req(st_req),
    .ee_busy(ee_busy), .lock_val(lock_val), .fuse_val(fuse_val),
    .flash_rdata(flash_rdata), .ld_data(ld_data), .ld_redirect(ld_redirect)
  );

  always @(posedge clk) begin
    bit hit;
    bit stop;
    hit = m_armed && (m_cnt < 3) && !ee_busy && ld_req &&
          (zptr == 16'h0000 || zptr == 16'h0001);
    if (rst) begin
      m_armed = 0; m_cnt = 0; m_seen = 0; m_data = '0; m_red = 0;
    end else begin
      if (hit) m_data = (zptr == 16'h0000) ? fuse_val : {6'b0, lock_val};
      else     m_data = flash_rdata;
      m_red = hit;
      if (ctl_wr && !ee_busy) begin
        m_armed = ctl_wdata[3] && ctl_wdata[0];
        m_cnt = 0; m_seen = 0;
      end else if (m_armed) begin
        stop = hit || st_req || (m_cnt == 3) || (m_cnt == 2 && !m_seen && !ld_req);
        if (stop) begin
          m_armed = 0; m_cnt = 0; m_seen = 0;
        end else begin
          m_seen = m_seen || ld_req;
          m_cnt++;
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    logic [7:0] exp_ctl;
    if (!done) begin
      exp_ctl = m_armed ? 8'h09 : 8'h00;
      total++;
      if (ld_data !== m_data || ld_redirect !== m_red || ctl_rdata !== exp_ctl) begin
        bad++;
        $display("FAIL %s: got data=%h red=%b ctl=%h expected data=%h red=%b ctl=%h",
                 tag, ld_data, ld_redirect, ctl_rdata, m_data, m_red, exp_ctl);
      end
    end
  end

  task automatic cyc(input bit wr, input logic [7:0] wd, input logic [15:0] z,
                     input bit ld, input bit st, input bit busy);
    @(negedge clk);
    #1;
    ctl_wr = wr; ctl_wdata = wd; zptr = z; ld_req = ld; st_req = st;
    ee_busy = busy; flash_rdata = 8'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 16'h4321, 0, 0, 0);
  endtask

  task automatic arm();
    cyc(1, 8'h09, 16'h4321, 0, 0, 0);
  endtask

  initial begin
    #40000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    idle(3);
    cyc(0, 8'h00, 16'h4321, 0, 0, 0);
    rst = 1'b0;
    idle(2);
    tag = "R10";
    for (int i = 0; i < 4; i++) cyc(0, 8'h00, 16'(i & 1), 1, 0, 0);
    idle(1);
    tag = "R2";
    cyc(1, 8'h08, 16'h0001, 0, 0, 0);
    cyc(0, 8'h00, 16'h0001, 1, 0, 0);
    cyc(1, 8'h01, 16'h0001, 0, 0, 0);
    cyc(0, 8'h00, 16'h0001, 1, 0, 0);
    arm();
    cyc(1, 8'hF6, 16'h4321, 0, 0, 0);
    idle(2);
    for (int d = 0; d < 4; d++) begin
      tag = (d == 3) ? "R6" : "R3";
      arm();
      idle(d);
      cyc(0, 8'h00, 16'h0001, 1, 0, 0);
      tag = "R5";
      cyc(0, 8'h00, 16'h0001, 1, 0, 0);
      idle(3);
    end
    tag = "R4";
    lock_val = 2'b01; fuse_val = 8'h3C;
    for (int d = 0; d < 3; d++) begin
      arm();
      idle(d);
      cyc(0, 8'h00, 16'h0000, 1, 0, 0);
      idle(2);
    end
    tag = "R6";
    arm(); idle(5);
    tag = "R8";
    arm();
    cyc(0, 8'h00, 16'h0002, 1, 0, 0);
    cyc(0, 8'h00, 16'h0001, 1, 0, 0);
    idle(2);
    tag = "R7";
    arm();
    cyc(0, 8'h00, 16'h8000, 1, 0, 0);
    idle(5);
    arm();
    cyc(0, 8'h00, 16'h0100, 1, 0, 0);
    cyc(0, 8'h00, 16'h4321, 0, 1, 0);
    cyc(0, 8'h00, 16'h0001, 1, 0, 0);
    idle(2);
    arm();
    cyc(0, 8'h00, 16'h0100, 1, 0, 0);
    idle(2);
    cyc(0, 8'h00, 16'h0000, 1, 0, 0);
    idle(2);
    tag = "R9";
    cyc(1, 8'h09, 16'h4321, 0, 0, 1);
    cyc(0, 8'h00, 16'h0001, 1, 0, 1);
    cyc(0, 8'h00, 16'h0001, 1, 0, 0);
    arm();
    cyc(0, 8'h00, 16'h0000, 1, 0, 1);
    cyc(1, 8'h00, 16'h4321, 0, 0, 1);
    cyc(0, 8'h00, 16'h0000, 1, 0, 0);
    idle(3);
    tag = "R11";
    arm();
    cyc(1, 8'h09, 16'h0001, 1, 0, 0);
    idle(2);
    cyc(0, 8'h00, 16'h0001, 1, 0, 0);
    idle(1);
    arm(); idle(1);
    cyc(1, 8'h09, 16'h4321, 0, 1, 0);
    idle(3);
    cyc(0, 8'h00, 16'h0000, 1, 0, 0);
    idle(2);
    tag = "R12";
    lock_val = 2'b11; fuse_val = 8'h81;
    for (int k = 0; k < 40; k++) begin
      cyc(($urandom % 5) == 0, (($urandom % 2) == 0) ? 8'h09 : 8'(($urandom)),
          16'($urandom % 3), ($urandom % 2) == 1, ($urandom % 9) == 0,
          ($urandom % 7) == 0);
    end
    idle(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule